// File: doc/BRIEF.md
# Sticky Fault Register with One-Shot Alert

This block collects single-cycle fault event pulses from monitoring comparators into a sticky fault register. A latched bit records that the fault happened at some point, whether or not it is still present. The block drives an active-low alert towards the host. The alert is meant for an open-drain pad: 0 means pull the wire low, 1 means release it. A per-fault enable register decides which latched faults may pull the alert. The same register also carries the data bit for a general-purpose output pin.

The alert is one-shot per fault bit. When the host acknowledges with a release pulse, every fault bit that is set at that moment is marked as reported. A reported bit cannot pull the alert again, even if its fault keeps recurring. The bit re-arms only after the host clears it. A different, unreported fault bit can raise the alert at any time.

The block also logs an undervoltage that is present when the internal supply comes out of lockout. This covers power-up, when the undervoltage exists before any comparator edge could report it.

The host writes through a valid/ready command channel. `cmd_ready` is held high, so a command is accepted in every cycle where `cmd_valid` is high, and the channel never applies back-pressure. Reads are combinational through `rd_sel`.

Top module: `fault_alert_ctrl`

## Requirements
- R1: After reset, all fault bits, reported flags and enable bits are 0, `alert_n` is 1 and `gpio_out` is 0.
- R2: A pulse on `fault_evt[i]` sets fault bit i at the next clock edge. The bit stays set until the host clears it.
- R3: A write with `cmd_sel`=0 (fault register) clears each fault bit i whose `cmd_data[i]` is 0. Bits written 1 are left unchanged, so a write can never set a fault bit.
- R4: When a clear and a fault event hit the same bit in the same cycle, the event wins and the bit is 1 afterwards. The bit also counts as unreported afterwards.
- R5: A write with `cmd_sel`=1 loads the enable register. Bits 0..NUM_FAULTS-1 are per-fault enables. `alert_n` is 0 exactly when some fault bit is set, enabled and not yet reported.
- R6: A pulse on `alert_release` marks every fault bit set in that cycle as reported. If no new fault latches in that cycle, `alert_n` is 1 after the edge.
- R7: Clearing a fault bit also clears its reported flag. If that fault then sets again, it pulls `alert_n` low again when enabled.
- R8: A repeated event on a reported bit leaves `alert_n` at 1. A newly set, enabled bit that differs from the reported ones drives `alert_n` to 0.
- R9: A rising edge of `supply_ok` while `uv_level` is 1 sets fault bit 0 (undervoltage). This includes `supply_ok` already being high in the first cycle after reset. A rising edge while `uv_level` is 0 sets nothing.
- R10: Bit 6 of the enable register drives `gpio_out`. Bit 7 is not stored and reads 0.
- R11: `cmd_ready` is always 1. `rd_data` shows the fault bits zero-extended when `rd_sel`=0, and the enable register when `rd_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_evt | input | NUM_FAULTS | One pulse per detected fault, one bit per fault |
| supply_ok | input | 1 | Internal supply out of lockout (level) |
| uv_level | input | 1 | Undervoltage comparator level |
| alert_release | input | 1 | Host acknowledge pulse for the alert |
| cmd_valid | input | 1 | Register write command valid |
| cmd_ready | output | 1 | Write command accepted (always 1) |
| cmd_sel | input | 1 | Write target: 0 fault register, 1 enable register |
| cmd_data | input | REG_W | Write data |
| rd_sel | input | 1 | Read select: 0 fault register, 1 enable register |
| rd_data | output | REG_W | Read data for the selected register |
| alert_n | output | 1 | Active-low alert; 0 pulls the open-drain line |
| gpio_out | output | 1 | General-purpose output data bit |

## Verification
The alert logic is tried with several event patterns:

- Single events, which show that a fault latches and stays latched.
- Events repeated on a bit that is already reported, which separate one-shot behaviour from level behaviour.
- Events on a new bit after a release, which show that a different fault still raises the alert.
- Clears coinciding with events, which expose the priority between clearing and setting.

Disabled faults that are enabled later show whether masking acts on the stored state or only on fresh events. Supply rises with and without undervoltage show that the power-up logging depends on both the edge and the level.

// File: rtl/fault_alert_pkg.sv
package fault_alert_pkg;

  typedef enum logic {
    SEL_FAULT = 1'b0,
    SEL_CFG   = 1'b1
  } reg_sel_e;

  // Mask of the storable bits in the enable register: per-fault enables plus GPIO data.
  function automatic logic [31:0] cfg_mask(input int nf, input int gpio_bit);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < nf; i++) m[i] = 1'b1;
    m[gpio_bit] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/fault_cell.sv
module fault_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  input  logic mark_i,
  output logic fault_o,
  output logic rep_o
);
  logic fault_q, rep_q;
  logic fault_d, rep_d;

  always_comb begin
    fault_d = (fault_q & ~clr_i) | evt_i;
    rep_d   = (rep_q | (mark_i & fault_q)) & ~clr_i & fault_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      rep_q   <= 1'b0;
    end else begin
      fault_q <= fault_d;
      rep_q   <= rep_d;
    end
  end

  assign fault_o = fault_q;
  assign rep_o   = rep_q;

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !clr_i) |=> fault_q);
  // R4
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> fault_q);
  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt_i) |=> !fault_q);
  // R7
  clear_rearms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !rep_q);
  // R7
  rep_needs_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_q |-> fault_q);
endmodule

// File: rtl/cfg_reg.sv
module cfg_reg #(
  parameter int REG_W      = 8,
  parameter int NUM_FAULTS = 6,
  parameter int GPIO_BIT   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] data_i,
  output logic [REG_W-1:0] cfg_o,
  output logic             gpio_o
);
  import fault_alert_pkg::*;

  localparam logic [31:0]      MASK32 = cfg_mask(NUM_FAULTS, GPIO_BIT);
  localparam logic [REG_W-1:0] MASK   = MASK32[REG_W-1:0];

  logic [REG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (wr_i) cfg_q <= data_i & MASK;
  end

  assign cfg_o  = cfg_q;
  assign gpio_o = cfg_q[GPIO_BIT];

  // R10
  gpio_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> gpio_o == $past(data_i[GPIO_BIT]));
endmodule

// File: rtl/supply_edge.sv
module supply_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic uv_level_i,
  output logic uv_set_o
);
  logic ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b0;
    else        ok_q <= supply_ok_i;
  end

  assign uv_set_o = supply_ok_i & ~ok_q & uv_level_i;
endmodule

// File: rtl/fault_alert_ctrl.sv
module fault_alert_ctrl #(
  parameter int NUM_FAULTS = 6,
  parameter int REG_W      = 8,
  parameter int GPIO_BIT   = 6,
  parameter int UV_BIT     = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FAULTS-1:0] fault_evt,
  input  logic                  supply_ok,
  input  logic                  uv_level,
  input  logic                  alert_release,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic                  cmd_sel,
  input  logic [REG_W-1:0]      cmd_data,
  input  logic                  rd_sel,
  output logic [REG_W-1:0]      rd_data,
  output logic                  alert_n,
  output logic                  gpio_out
);
  import fault_alert_pkg::*;

  localparam int PAD_W = REG_W - NUM_FAULTS;

  logic                  uv_set;
  logic                  wr_fault, wr_cfg;
  logic [NUM_FAULTS-1:0] set_vec, clr_vec, fault_vec, rep_vec, pend_vec;
  logic [REG_W-1:0]      cfg_q;

  assign cmd_ready = 1'b1;
  assign wr_fault  = cmd_valid && (reg_sel_e'(cmd_sel) == SEL_FAULT);
  assign wr_cfg    = cmd_valid && (reg_sel_e'(cmd_sel) == SEL_CFG);

  supply_edge u_supply (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok_i(supply_ok),
    .uv_level_i (uv_level),
    .uv_set_o   (uv_set)
  );

  always_comb begin
    set_vec         = fault_evt;
    set_vec[UV_BIT] = fault_evt[UV_BIT] | uv_set;
    clr_vec         = wr_fault ? ~cmd_data[NUM_FAULTS-1:0] : '0;
  end

  for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_cell
    fault_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (set_vec[i]),
      .clr_i  (clr_vec[i]),
      .mark_i (alert_release),
      .fault_o(fault_vec[i]),
      .rep_o  (rep_vec[i])
    );
  end

  cfg_reg #(
    .REG_W     (REG_W),
    .NUM_FAULTS(NUM_FAULTS),
    .GPIO_BIT  (GPIO_BIT)
  ) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_i  (wr_cfg),
    .data_i(cmd_data),
    .cfg_o (cfg_q),
    .gpio_o(gpio_out)
  );

  assign pend_vec = fault_vec & cfg_q[NUM_FAULTS-1:0] & ~rep_vec;
  assign alert_n  = ~(|pend_vec);
  assign rd_data  = (reg_sel_e'(rd_sel) == SEL_CFG) ? cfg_q
                                                   : {{PAD_W{1'b0}}, fault_vec};

  // R6
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_release && set_vec == '0) |=> alert_n);
  // R8
  no_spurious_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_n && set_vec == '0 && !wr_cfg) |=> alert_n);
  // R9
  uv_logged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_set |=> fault_vec[UV_BIT]);
endmodule

// File: tb/fault_alert_ctrl_bench.sv
module fault_alert_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] fault_evt = '0;
  logic       supply_ok = 1'b0, uv_level = 1'b0, alert_release = 1'b0;
  logic       cmd_valid = 1'b0, cmd_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] cmd_data = '0;
  logic       cmd_ready, alert_n, gpio_out;
  logic [7:0] rd_data;

  always #10 clk = ~clk;

  fault_alert_ctrl u_fault_alert_ctrl (
    .clk(clk), .rst_n(rst_n), .fault_evt(fault_evt), .supply_ok(supply_ok),
    .uv_level(uv_level), .alert_release(alert_release), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_sel(cmd_sel), .cmd_data(cmd_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .alert_n(alert_n), .gpio_out(gpio_out)
  );

  // Behavioural reference model
  int    m_fault[6];
  int    m_rep[6];
  int    m_en;
  int    m_ok_prev;
  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  string tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_fault[i]) begin m_fault[i] = 0; m_rep[i] = 0; end
      m_en = 0; m_ok_prev = 0;
    end else begin
      int uvhit;
      uvhit = (supply_ok && !m_ok_prev && uv_level) ? 1 : 0;
      m_ok_prev = supply_ok;
      for (int i = 0; i < 6; i++) begin
        int ev, cl, nf, nr;
        ev = (fault_evt[i] || (i == 0 && uvhit == 1)) ? 1 : 0;
        cl = (cmd_valid && cmd_sel == 1'b0 && cmd_data[i] == 1'b0) ? 1 : 0;
        nf = ((m_fault[i] == 1 && cl == 0) || ev == 1) ? 1 : 0;
        nr = ((m_rep[i] == 1 || (alert_release && m_fault[i] == 1)) && cl == 0 && nf == 1) ? 1 : 0;
        m_fault[i] = nf; m_rep[i] = nr;
      end
      if (cmd_valid && cmd_sel == 1'b1) m_en = int'(cmd_data) % 128;
    end
  end

  function automatic int exp_faults();
    int v = 0;
    for (int i = 0; i < 6; i++) if (m_fault[i] == 1) v += (1 << i);
    return v;
  endfunction

  function automatic bit exp_alert_n();
    for (int i = 0; i < 6; i++)
      if (m_fault[i] == 1 && m_rep[i] == 0 && ((m_en >> i) % 2) == 1) return 1'b0;
    return 1'b1;
  endfunction

  task automatic compare();
    int er;
    er = rd_sel ? m_en : exp_faults();
    n_cmp++;
    if (alert_n !== exp_alert_n()) begin
      n_bad++; $display("FAIL %s alert_n act=%b exp=%b", tag, alert_n, exp_alert_n());
    end
    n_cmp++;
    if (rd_data !== 8'(er)) begin
      n_bad++; $display("FAIL %s rd_data(sel=%0d) act=%h exp=%h", tag, rd_sel, rd_data, er);
    end
    n_cmp++;
    if (gpio_out !== 1'((m_en >> 6) % 2)) begin
      n_bad++; $display("FAIL %s gpio_out act=%b exp=%b", tag, gpio_out, (m_en >> 6) % 2);
    end
    n_cmp++;
    if (cmd_ready !== 1'b1) begin
      n_bad++; $display("FAIL R11 cmd_ready act=%b exp=1", cmd_ready);
    end
  endtask

  // One cycle: check the outputs of the previous edge, then drive this cycle's inputs.
  task automatic step(input string t, input logic [5:0] ev, input logic rel,
                      input logic cv, input logic cs, input logic [7:0] cd);
    @(negedge clk);
    compare();
    tag = t;
    rd_sel = ~rd_sel;
    fault_evt = ev; alert_release = rel;
    cmd_valid = cv; cmd_sel = cs; cmd_data = cd;
  endtask

  task automatic idle(input string t, input int n);
    for (int k = 0; k < n; k++) step(t, '0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  // Explicit check of the alert line against a fixed expectation
  task automatic expect_alert(input string t, input logic e);
    @(negedge clk);
    n_cmp++;
    if (alert_n !== e) begin
      n_bad++; $display("FAIL %s alert_n act=%b exp=%b", t, alert_n, e);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle("R1", 3);
    // R10 / R11: enable everything, including GPIO data; bit 7 is dropped
    step("R10", '0, 0, 1, 1, 8'hFF);
    idle("R10", 2);
    step("R10", '0, 0, 1, 1, 8'h3F);
    idle("R11", 2);
    // R2: single event latches and holds
    step("R2", 6'b000100, 0, 0, 0, '0);
    idle("R2", 3);
    expect_alert("R5", 1'b0);
    // R6: release, then the same fault repeats
    step("R6", '0, 1, 0, 0, '0);
    idle("R6", 2);
    step("R8", 6'b000100, 0, 0, 0, '0);
    idle("R8", 2);
    expect_alert("R8", 1'b1);
    // R8: a different bit raises it again
    step("R8", 6'b010000, 0, 0, 0, '0);
    idle("R8", 2);
    step("R6", '0, 1, 0, 0, '0);
    idle("R6", 2);
    // R3: writing ones changes nothing; writing 0 to bit 2 clears it
    step("R3", '0, 0, 1, 0, 8'hFF);
    idle("R3", 2);
    step("R3", '0, 0, 1, 0, 8'hFB);
    idle("R3", 2);
    // R7: the cleared bit re-arms
    step("R7", 6'b000100, 0, 0, 0, '0);
    idle("R7", 2);
    expect_alert("R7", 1'b0);
    step("R7", '0, 1, 0, 0, '0);
    idle("R7", 2);
    // R4: clear and event on bit 4 together
    step("R4", 6'b010000, 0, 1, 0, 8'hEF);
    idle("R4", 2);
    step("R4", '0, 1, 0, 0, '0);
    // Release coinciding with a new fault on bit 3
    step("R6", 6'b001000, 1, 0, 0, '0);
    idle("R6", 2);
    step("R6", '0, 1, 0, 0, '0);
    idle("R6", 2);
    // R5: disabled fault latches quietly, alerts once enabled
    step("R5", '0, 0, 1, 1, 8'h00);
    step("R5", '0, 0, 1, 0, 8'h00);
    step("R5", 6'b000010, 0, 0, 0, '0);
    idle("R5", 2);
    expect_alert("R5", 1'b1);
    step("R5", '0, 0, 1, 1, 8'h02);
    idle("R5", 2);
    step("R5", '0, 1, 0, 0, '0);
    // All faults at once, with all enabled
    step("R2", '0, 0, 1, 1, 8'h7F);
    step("R2", 6'b111111, 0, 0, 0, '0);
    idle("R2", 2);
    step("R6", '0, 1, 0, 0, '0);
    step("R3", '0, 0, 1, 0, 8'h00);
    idle("R3", 2);
    // R9: supply rises with undervoltage present, then without
    uv_level = 1'b1;
    idle("R9", 1);
    supply_ok = 1'b1;
    idle("R9", 3);
    expect_alert("R9", 1'b0);
    step("R9", '0, 1, 1, 0, 8'h00);
    supply_ok = 1'b0; uv_level = 1'b0;
    idle("R9", 2);
    supply_ok = 1'b1;
    idle("R9", 3);
    // R1: reset with supply already up and undervoltage present logs it at power-up
    @(negedge clk); rst_n = 1'b0; uv_level = 1'b1;
    idle("R1", 1);
    @(negedge clk); rst_n = 1'b1;
    idle("R9", 4);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule